// File: doc/BRIEF.md
# Masked Dual Calendar Alarm

This block watches a running calendar and raises interrupt flags when it matches either of two alarms that the host programs. Each alarm has a compare value for six calendar fields: second, minute, hour, date, month and weekday. Each field also has its own enable bit, and only the enabled fields take part in the match. With this one comparator, an alarm can fire at a chosen second, minute, hour, date, weekday or month, or at any mix of these.

The calendar source pulses a one-cycle tick once per second, in the cycle where the new calendar value is on the bus. The alarms are evaluated only in that cycle. An alarm in one-shot mode fires once and then disarms itself. An alarm in repeat mode stays armed and fires on every matching tick, which gives a periodic interrupt. Each alarm has a sticky status flag, which the host clears by writing 1. The interrupt output combines the flags of the alarms whose interrupt enable is set.

The host reaches the registers through a simple write port and a combinational read port. The address is {alarm index, 2-bit select}. Select 0 is the compare value, select 1 is control, select 2 is status, and select 3 reads as zero.

Top module: `dual_cal_alarm`

## Requirements
- R1: After reset, every compare value, control word and flag is zero, and `irq_o` is low.
- R2: A write to select 0 stores the compare value, packed as second [5:0], minute [11:6], hour [16:12], date [21:17], month [25:22] and weekday [28:26]. A write to select 1 stores control: field enables [5:0] (bit 0 second, 1 minute, 2 hour, 3 date, 4 month, 5 weekday), repeat [6], armed [7] and interrupt enable [8]. Both registers read back unchanged.
- R3: On a tick, an armed alarm fires when every enabled field of `cal_i` equals its compare field. Disabled fields are ignored. The flag is visible one cycle after the tick.
- R4: An armed alarm with all six field enables cleared never fires.
- R5: A one-shot alarm (repeat 0) that fires sets its flag and clears its armed bit.
- R6: A repeat alarm that fires stays armed and fires again on later matching ticks.
- R7: An alarm whose armed bit is clear never fires.
- R8: A flag stays set until the host writes a 1 to bit 0 of that alarm's status select. Writing 0 there leaves the flag unchanged.
- R9: `irq_o` is high exactly when some alarm has both its flag and its interrupt enable set.
- R10: When both alarms match on the same tick, both flags set in that same cycle.
- R11: If an alarm fires in the same cycle as a status clear for that alarm, the flag ends up set.
- R12: Without a tick, no alarm fires, whatever the calendar value is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse once per second; `cal_i` is valid with it |
| cal_i | input | 29 | Current calendar, packed as in R2 |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Write address {alarm, select} |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address {alarm, select} |
| rd_data | output | 32 | Combinational read data |
| flag_o | output | 2 | Sticky match flag per alarm |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that `tick_i` is a single-cycle pulse and that `cal_i` already holds the updated calendar in the tick cycle. They also assume that a host write to an alarm's control register may override the self-disarm in that same cycle, so the armed-bit properties exclude such cycles. The random stimulus draws every calendar and compare field from only two values, so partial and full matches happen often. Ticks, control writes and status clears land at random times, including in the same cycle, which exercises the set-over-clear and write-override orderings.

// File: rtl/cal_alarm_pkg.sv
`timescale 1ns/1ps
package cal_alarm_pkg;
    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int DATE_W = 5;
    localparam int MON_W  = 4;
    localparam int WDAY_W = 3;
    localparam int N_FLD  = 6;

    typedef struct packed {
        logic [WDAY_W-1:0] wday;
        logic [MON_W-1:0]  month;
        logic [DATE_W-1:0] date;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } cal_t;

    localparam int CAL_W = $bits(cal_t);

    typedef struct packed {
        logic             irq_en;
        logic             armed;
        logic             rpt;
        logic [N_FLD-1:0] en;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic int fld_w(input int f);
        case (f)
            0: return SEC_W;
            1: return MIN_W;
            2: return HOUR_W;
            3: return DATE_W;
            4: return MON_W;
            default: return WDAY_W;
        endcase
    endfunction

    function automatic int fld_lo(input int f);
        int acc = 0;
        for (int k = 0; k < f; k++) acc += fld_w(k);
        return acc;
    endfunction
endpackage

// File: rtl/alm_match.sv
`timescale 1ns/1ps
module alm_match
    import cal_alarm_pkg::*;
(
    input  cal_t             cal_i,
    input  cal_t             cmp_i,
    input  logic [N_FLD-1:0] en_i,
    output logic             hit_o
);
    logic [CAL_W-1:0] cal_v;
    logic [CAL_W-1:0] cmp_v;
    logic [N_FLD-1:0] fld_ok;

    assign cal_v = cal_i;
    assign cmp_v = cmp_i;

    // one comparator slice per calendar field; a masked field always agrees
    for (genvar f = 0; f < N_FLD; f++) begin : g_fld
        localparam int LO = fld_lo(f);
        localparam int W  = fld_w(f);
        assign fld_ok[f] = !en_i[f] || (cal_v[LO +: W] == cmp_v[LO +: W]);
    end

    // an empty mask must never count as a match
    assign hit_o = (|en_i) && (&fld_ok);
endmodule

// File: rtl/alm_unit.sv
`timescale 1ns/1ps
module alm_unit
    import cal_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  cal_t cal_i,
    input  logic wr_val,
    input  logic wr_ctl,
    input  logic wr_clr,
    input  cal_t wval_i,
    input  ctl_t wctl_i,
    output cal_t val_o,
    output ctl_t ctl_o,
    output logic flag_o
);
    typedef struct packed {
        cal_t val;
        ctl_t ctl;
        logic flag;
    } st_t;

    st_t  st_d, st_q;
    logic hit;
    logic fire;

    alm_match u_match (
        .cal_i (cal_i),
        .cmp_i (st_q.val),
        .en_i  (st_q.ctl.en),
        .hit_o (hit)
    );

    assign fire = tick_i & st_q.ctl.armed & hit;

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.flag = 1'b1;
            if (!st_q.ctl.rpt) st_d.ctl.armed = 1'b0;
        end
        if (wr_val) st_d.val = wval_i;
        if (wr_ctl) st_d.ctl = wctl_i;
        if (wr_clr && !fire) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_o  = st_q.val;
    assign ctl_o  = st_q.ctl;
    assign flag_o = st_q.flag;

    p_flag_on_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(tick_i));
    p_oneshot_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !st_q.ctl.rpt && !wr_ctl) |=> !st_q.ctl.armed);
    p_repeat_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && st_q.ctl.rpt && !wr_ctl) |=> st_q.ctl.armed);
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !wr_clr) |=> st_q.flag);
    p_empty_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl.en == '0) |-> !hit);
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && wr_clr) |=> st_q.flag);
endmodule

// File: rtl/dual_cal_alarm.sv
`timescale 1ns/1ps
module dual_cal_alarm
    import cal_alarm_pkg::*;
#(
    parameter int N_ALM  = 2,
    parameter int DATA_W = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                tick_i,
    input  logic [CAL_W-1:0]                    cal_i,
    input  logic                                wr_en,
    input  logic [$clog2(N_ALM)+1:0]            wr_addr,
    input  logic [DATA_W-1:0]                   wr_data,
    input  logic [$clog2(N_ALM)+1:0]            rd_addr,
    output logic [DATA_W-1:0]                   rd_data,
    output logic [N_ALM-1:0]                    flag_o,
    output logic                                irq_o
);
    localparam int IDX_W  = $clog2(N_ALM);
    localparam int ADDR_W = IDX_W + 2;
    localparam logic [1:0] SEL_VAL = 2'd0;
    localparam logic [1:0] SEL_CTL = 2'd1;
    localparam logic [1:0] SEL_STS = 2'd2;

    cal_t             val_q [N_ALM];
    ctl_t             ctl_q [N_ALM];
    logic [N_ALM-1:0] ien;
    logic             unused_wr_hi;

    assign unused_wr_hi = ^wr_data[DATA_W-1:CAL_W];

    for (genvar i = 0; i < N_ALM; i++) begin : g_alm
        logic sel_me;
        assign sel_me = wr_en && (wr_addr[ADDR_W-1:2] == IDX_W'(i));

        alm_unit u_unit (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick_i),
            .cal_i  (cal_t'(cal_i)),
            .wr_val (sel_me && wr_addr[1:0] == SEL_VAL),
            .wr_ctl (sel_me && wr_addr[1:0] == SEL_CTL),
            .wr_clr (sel_me && wr_addr[1:0] == SEL_STS && wr_data[0]),
            .wval_i (cal_t'(wr_data[CAL_W-1:0])),
            .wctl_i (ctl_t'(wr_data[CTL_W-1:0])),
            .val_o  (val_q[i]),
            .ctl_o  (ctl_q[i]),
            .flag_o (flag_o[i])
        );
        assign ien[i] = ctl_q[i].irq_en;
    end

    assign irq_o = |(flag_o & ien);

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_ALM; i++) begin
            if (rd_addr[ADDR_W-1:2] == IDX_W'(i)) begin
                case (rd_addr[1:0])
                    SEL_VAL: rd_data = DATA_W'(val_q[i]);
                    SEL_CTL: rd_data = DATA_W'(ctl_q[i]);
                    SEL_STS: rd_data = DATA_W'(flag_o[i]);
                    default: rd_data = '0;
                endcase
            end
        end
    end

    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag_o != '0));
endmodule

// File: tb/dual_cal_alarm_tb.sv
`timescale 1ns/1ps
module dual_cal_alarm_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [28:0] cal_i = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [1:0]  flag_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int cyc_n = 0;

    logic [28:0] m_val [2];
    logic [8:0]  m_ctl [2];
    bit          m_flag [2];

    always #2 clk = ~clk;

    dual_cal_alarm u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cal_i(cal_i),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .flag_o(flag_o), .irq_o(irq_o)
    );

    function automatic logic [28:0] mk(int s, int mi, int h, int d, int mo, int w);
        return {w[2:0], mo[3:0], d[4:0], h[4:0], mi[5:0], s[5:0]};
    endfunction

    function automatic logic [31:0] mkctl(logic [5:0] en, bit rpt, bit arm, bit ie);
        return {23'd0, ie, arm, rpt, en};
    endfunction

    function automatic bit m_hit(int i, logic [28:0] cal);
        int w [6] = '{6, 6, 5, 5, 4, 3};
        int lo = 0;
        bit ok;
        if (!m_ctl[i][7] || m_ctl[i][5:0] == 0) return 0;
        ok = 1;
        for (int f = 0; f < 6; f++) begin
            if (m_ctl[i][f] && (((cal >> lo) ^ (m_val[i] >> lo)) & ((29'd1 << w[f]) - 1)) != 0)
                ok = 0;
            lo += w[f];
        end
        return ok;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(string tag, bit tk, logic [28:0] cal, bit we, logic [2:0] a, logic [31:0] d);
        bit hit [2];
        int i;
        tick_i = tk; cal_i = cal; wr_en = we; wr_addr = a; wr_data = d;
        for (int k = 0; k < 2; k++) hit[k] = tk && m_hit(k, cal);
        @(posedge clk);
        for (int k = 0; k < 2; k++) begin
            if (hit[k]) begin
                m_flag[k] = 1;
                if (!m_ctl[k][6]) m_ctl[k][7] = 1'b0;
            end
            if (we && a[2] == k[0]) begin
                if (a[1:0] == 2'd0) m_val[k] = d[28:0];
                if (a[1:0] == 2'd1) m_ctl[k] = d[8:0];
                if (a[1:0] == 2'd2 && d[0] && !hit[k]) m_flag[k] = 0;
            end
        end
        @(negedge clk);
        tick_i = 0; wr_en = 0;
        cyc_n++;
        check(tag, "flags", {30'd0, flag_o}, {30'd0, m_flag[1], m_flag[0]});
        check(tag, "irq", {31'd0, irq_o},
              {31'd0, (m_flag[0] & m_ctl[0][8]) | (m_flag[1] & m_ctl[1][8])});
        i = cyc_n % 2;
        rd_addr = {i[0], 2'd1};
        #0.5;
        check(tag, "control readback", rd_data, {23'd0, m_ctl[i]});
        rd_addr = {i[0], 2'd0};
        #0.5;
        check(tag, "value readback", rd_data, {3'd0, m_val[i]});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [28:0] m;
        void'($urandom(32'd5150));
        for (int k = 0; k < 2; k++) begin m_val[k] = '0; m_ctl[k] = '0; m_flag[k] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at every register
        check("R1", "flags", {30'd0, flag_o}, 32'd0);
        check("R1", "irq", {31'd0, irq_o}, 32'd0);
        for (int a = 0; a < 8; a++) begin
            rd_addr = a[2:0];
            #0.2;
            check("R1", "register", rd_data, 32'd0);
        end

        m = mk(5, 2, 7, 1, 1, 1);
        cyc("R2", 0, '0, 1, 3'd0, {3'd0, mk(5, 2, 0, 0, 0, 0)});
        cyc("R2", 0, '0, 1, 3'd1, mkctl(6'b000011, 0, 1, 1));
        cyc("R3", 1, mk(5, 3, 7, 1, 1, 1), 0, 0, 0);   // minute differs
        cyc("R5", 1, m, 0, 0, 0);                      // fires, disarms
        cyc("R9", 0, m, 0, 0, 0);
        cyc("R8", 0, m, 1, 3'd2, 32'd0);               // write 0 keeps flag
        cyc("R8", 0, m, 1, 3'd2, 32'd1);               // write 1 clears
        cyc("R7", 1, m, 0, 0, 0);                      // disarmed
        cyc("R4", 0, m, 1, 3'd1, mkctl(6'b000000, 0, 1, 1));
        cyc("R4", 1, m, 0, 0, 0);
        cyc("R12", 0, m, 1, 3'd1, mkctl(6'b000001, 0, 1, 1));
        cyc("R12", 0, m, 0, 0, 0);
        cyc("R3", 1, m, 0, 0, 0);
        cyc("R8", 0, m, 1, 3'd2, 32'd1);
        cyc("R6", 0, m, 1, 3'd4, {3'd0, mk(10, 0, 0, 0, 0, 0)});
        cyc("R6", 0, m, 1, 3'd5, mkctl(6'b000001, 1, 1, 0));
        cyc("R6", 1, mk(10, 0, 3, 3, 3, 3), 0, 0, 0);
        cyc("R9", 0, m, 1, 3'd6, 32'd1);
        cyc("R6", 1, mk(10, 1, 3, 3, 3, 3), 0, 0, 0);
        cyc("R6", 0, m, 1, 3'd6, 32'd1);
        cyc("R10", 0, m, 1, 3'd0, {3'd0, mk(10, 9, 9, 9, 9, 0)});
        cyc("R10", 0, m, 1, 3'd1, mkctl(6'b000001, 0, 1, 1));
        cyc("R10", 1, mk(10, 5, 5, 5, 5, 5), 0, 0, 0);
        cyc("R11", 0, m, 1, 3'd2, 32'd1);
        cyc("R11", 0, m, 1, 3'd1, mkctl(6'b000001, 0, 1, 1));
        cyc("R11", 1, mk(10, 0, 0, 0, 0, 0), 1, 3'd2, 32'd1);

        for (int n = 0; n < 3000; n++) begin
            bit tk = ($urandom % 3) == 0;
            bit we = ($urandom % 3) == 0;
            logic [1:0] sel = 2'($urandom % 3);
            logic [2:0] a = {1'($urandom), sel};
            logic [31:0] d;
            logic [28:0] c = mk($urandom % 2, $urandom % 2, $urandom % 2,
                                $urandom % 2, $urandom % 2, $urandom % 2);
            if (sel == 2'd0)
                d = {3'd0, mk($urandom % 2, $urandom % 2, $urandom % 2,
                              $urandom % 2, $urandom % 2, $urandom % 2)};
            else if (sel == 2'd1)
                d = mkctl(6'($urandom), 1'($urandom), ($urandom % 4) != 0, 1'($urandom));
            else
                d = {31'd0, 1'($urandom)};
            cyc("R3", tk, c, we, a, d);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule